// File: doc/BRIEF.md
# Watchdog and Alarm Down Counter

This block is a 24-bit down counter paired with a seed register. It is reached through a small byte-wide register port at byte addresses 4, 5 and 6. A host write to any of those bytes updates that byte of the seed. The whole counter is then reloaded from the new seed, and the tick prescaler is restarted. Level inputs supplied by a control register elsewhere set the behaviour: counter enable, mode, interrupt enable and interrupt-output select. The block keeps an alarm flag that the host can clear.

In repeating-alarm mode the counter steps down once per second. When it reaches zero it raises the flag, reloads from the seed and carries on. In watchdog mode it steps at 4096 Hz. On reaching zero it raises the flag and halts. If interrupts are enabled and selected, it also drives a fixed-length active-low interrupt pulse of 250 ms that nothing can cut short. The flag clears on its own when that pulse ends.

A watchdog is kicked, meaning reloaded from the seed, in either of two ways. One is a rising edge on an external strobe pin, which passes through a two-flop synchronizer. The other is a register read, but only while the strobe is low. When the enable is off, the three bytes act as plain storage. An all-zero seed stops counting.

Top module: `wdalm_counter`

## Requirements
- R1: During and after reset, `rdata`, `alarm_flag` and `irq_oe` are 0, and the counter and seed hold 0.
- R2: An in-range write sets one seed byte: address 4 holds bits 7:0, address 5 holds bits 15:8 and address 6 holds bits 23:16. The counter loads the whole updated seed on the same edge, and the tick and second prescalers restart from zero.
- R3: With `mode_wd`=0 and counting active, the counter steps once every `SEC_TICKS` ticks. A tick is `TICK_DIV` clocks. When a step finds the count at 1 or 0, it reloads the seed and sets `alarm_flag`. Every other step subtracts exactly 1.
- R4: With `mode_wd`=1 and counting active, the counter steps on every tick. A step from 1 gives 0 and sets `alarm_flag`. A count of 0 then stays at 0 until a write or a kick.
- R5: A watchdog-mode timeout with `int_en`=1 and `int_sel`=1 raises `irq_oe` for exactly `TICK_DIV*PULSE_TICKS` clocks, while `irq_drv` stays 0. Raising `flag_clr` or dropping `int_en` during the pulse does not shorten it. `alarm_flag` is 0 after the pulse ends. No new pulse starts while one is running.
- R6: A read updates `rdata` one clock later, and `rdata` holds between reads. A read of address 4 returns count bits 7:0 and latches the full count as a snapshot. Reads of addresses 5 and 6 return the snapshot's middle and top bytes. A read of any other address returns 0. In alarm mode a read does not disturb counting.
- R7: In watchdog mode, a read of addresses 4 to 6 reloads the seed and restarts the prescaler, provided the synchronized strobe is low. While the strobe is high, a read reloads nothing.
- R8: A rising edge on `strobe` reloads the counter from the seed and restarts the prescaler when counting is active. The edge is seen after a two-flop synchronizer and an edge-detect flop.
- R9: With `cnt_en`=0 the counter neither steps nor kicks, and `alarm_flag` never rises. Writes and reads still work as in R2 and R6.
- R10: With an all-zero seed the counter does not step, and `alarm_flag` is never set.
- R11: `flag_clr` clears `alarm_flag` on the next edge. A timeout on the same edge takes priority and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, `TICK_DIV` cycles per 4096 Hz tick |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| addr | input | 3 | Register byte address |
| wr_en | input | 1 | Write strobe for `wdata` at `addr` |
| rd_en | input | 1 | Read strobe for `addr` |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| cnt_en | input | 1 | Counter enable; 0 turns the bytes into storage |
| mode_wd | input | 1 | 0 selects repeating alarm, 1 selects watchdog |
| int_en | input | 1 | Interrupt enable |
| int_sel | input | 1 | Interrupt-output select for the pin |
| flag_clr | input | 1 | Host clear of the alarm flag |
| strobe | input | 1 | Asynchronous watchdog kick input |
| alarm_flag | output | 1 | Alarm flag |
| irq_oe | output | 1 | Interrupt pin output enable; 1 drives the pin low |
| irq_drv | output | 1 | Interrupt pin data value, always 0 |

## Verification
The assertions assume that an out-of-range write or a strobe kick can only restart the counter from the seed, never load any other value. They also assume that the control levels change only between clock edges. The bench drives all inputs on the falling edge and never raises `rd_en` and `wr_en` together. It holds `strobe` steady long enough for the synchronizer to capture every level, so every kick is a clean edge. The pulse-length check depends on a pulse never being re-armed while it runs. The stimulus therefore lets each pulse end before it allows another timeout.

// File: rtl/wdalm_pkg.sv
package wdalm_pkg;
  // Source chosen for the counter's next value
  typedef enum logic [1:0] {
    LD_HOLD  = 2'd0,
    LD_WRITE = 2'd1,
    LD_SEED  = 2'd2,
    LD_STEP  = 2'd3
  } ld_e;
endpackage

// File: rtl/wdalm_edge.sv
module wdalm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], din};
  end

  assign level = sh_q[1];
  assign rise  = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/wdalm_prescale.sv
module wdalm_prescale #(
  parameter int TICK_DIV  = 8,
  parameter int SEC_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick,
  output logic sec_wrap
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int SEC_W = $clog2(SEC_TICKS + 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [SEC_W-1:0] sec_q, sec_d;

  assign tick     = (div_q == DIV_W'(TICK_DIV - 1));
  assign sec_wrap = tick && (sec_q == SEC_W'(SEC_TICKS - 1));

  always_comb begin
    div_d = div_q;
    sec_d = sec_q;
    if (clr) begin
      div_d = '0;
      sec_d = '0;
    end else if (tick) begin
      div_d = '0;
      sec_d = sec_wrap ? '0 : sec_q + 1'b1;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sec_q <= '0;
    end else begin
      div_q <= div_d;
      sec_q <= sec_d;
    end
  end
endmodule

// File: rtl/wdalm_pulse.sv
module wdalm_pulse #(
  parameter int PULSE_CYC = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int PC_W = $clog2(PULSE_CYC + 1);

  logic            act_q, act_d;
  logic [PC_W-1:0] pc_q, pc_d;

  assign active = act_q;
  assign done   = act_q && (pc_q == PC_W'(PULSE_CYC - 1));

  always_comb begin
    act_d = act_q;
    pc_d  = pc_q;
    if (act_q) begin
      if (done) begin
        act_d = 1'b0;
        pc_d  = '0;
      end else begin
        pc_d = pc_q + 1'b1;
      end
    end else if (start) begin
      act_d = 1'b1;
      pc_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      act_q <= act_d;
      pc_q  <= pc_d;
    end
  end
endmodule

// File: rtl/wdalm_counter.sv
module wdalm_counter #(
  parameter int CNT_W       = 24,
  parameter int ADDR_W      = 3,
  parameter int BASE_ADDR   = 4,
  parameter int TICK_DIV    = 8,
  parameter int SEC_TICKS   = 4096,
  parameter int PULSE_TICKS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              cnt_en,
  input  logic              mode_wd,
  input  logic              int_en,
  input  logic              int_sel,
  input  logic              flag_clr,
  input  logic              strobe,
  output logic              alarm_flag,
  output logic              irq_oe,
  output logic              irq_drv
);
  import wdalm_pkg::*;

  localparam int NB        = CNT_W / 8;
  localparam int BI_W      = $clog2(NB + 1);
  localparam int PULSE_CYC = TICK_DIV * PULSE_TICKS;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic str_lvl, str_rise, tick, sec_wrap, pre_clr;
  logic p_active, p_done, pulse_start;

  wdalm_edge u_edge (
    .clk(clk), .rst_n(rst_i_n), .din(strobe), .level(str_lvl), .rise(str_rise)
  );

  wdalm_prescale #(.TICK_DIV(TICK_DIV), .SEC_TICKS(SEC_TICKS)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .clr(pre_clr), .tick(tick), .sec_wrap(sec_wrap)
  );

  wdalm_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_i_n), .start(pulse_start), .active(p_active), .done(p_done)
  );

  logic [CNT_W-1:0] cnt_q, cnt_d, seed_q, seed_d, snap_q, snap_d;
  logic [7:0]       rdata_q, rdata_d, rd_byte;
  logic             flag_q, flag_d;
  logic             in_rng, wr_hit, rd_hit, run, kick, step, timeout, at_one, at_zero;
  logic [BI_W-1:0]  bidx;
  ld_e              ld;

  assign in_rng = (addr >= ADDR_W'(BASE_ADDR)) && (addr < ADDR_W'(BASE_ADDR + NB));
  assign bidx   = BI_W'(addr - ADDR_W'(BASE_ADDR));

  always_comb begin
    wr_hit  = wr_en && in_rng;
    rd_hit  = rd_en && in_rng;
    run     = cnt_en && (seed_q != '0);
    kick    = run && (str_rise || (rd_hit && mode_wd && !str_lvl));
    step    = run && (mode_wd ? tick : sec_wrap);
    at_one  = (cnt_q == CNT_W'(1));
    at_zero = (cnt_q == '0);

    seed_d = seed_q;
    for (int b = 0; b < NB; b++) begin
      if (wr_hit && (bidx == BI_W'(b))) seed_d[b*8 +: 8] = wdata;
    end

    if (wr_hit)    ld = LD_WRITE;
    else if (kick) ld = LD_SEED;
    else if (step) ld = LD_STEP;
    else           ld = LD_HOLD;

    timeout = (ld == LD_STEP) && (mode_wd ? at_one : (at_one || at_zero));

    case (ld)
      LD_WRITE: cnt_d = seed_d;
      LD_SEED:  cnt_d = seed_q;
      LD_STEP: begin
        if (!mode_wd && (at_one || at_zero)) cnt_d = seed_q;
        else if (at_zero)                    cnt_d = cnt_q;
        else                                 cnt_d = cnt_q - CNT_W'(1);
      end
      default:  cnt_d = cnt_q;
    endcase

    pre_clr     = wr_hit || kick;
    pulse_start = timeout && mode_wd && int_en && int_sel && !p_active;

    if (timeout)                flag_d = 1'b1;
    else if (flag_clr || p_done) flag_d = 1'b0;
    else                        flag_d = flag_q;

    rd_byte = '0;
    for (int b = 0; b < NB; b++) begin
      if (bidx == BI_W'(b)) rd_byte = (b == 0) ? cnt_q[7:0] : snap_q[b*8 +: 8];
    end

    snap_d  = snap_q;
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = in_rng ? rd_byte : 8'h00;
      if (rd_hit && (bidx == '0)) snap_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cnt_q   <= '0;
      seed_q  <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      seed_q  <= seed_d;
      snap_q  <= snap_d;
      rdata_q <= rdata_d;
      flag_q  <= flag_d;
    end
  end

  assign rdata      = rdata_q;
  assign alarm_flag = flag_q;
  assign irq_oe     = p_active;
  assign irq_drv    = 1'b0;
endmodule

// File: rtl/wdalm_counter_chk.sv
module wdalm_counter_chk #(
  parameter int CNT_W     = 24,
  parameter int PULSE_CYC = 8192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             mode_wd,
  input logic             wr_en,
  input logic             alarm_flag,
  input logic             irq_oe,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] seed,
  input logic             kick
);
  int hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len <= 0;
    else if (irq_oe) hi_len <= hi_len + 1;
    else             hi_len <= 0;
  end

  // R5: the pulse always lasts its full length
  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_oe) |-> (hi_len == PULSE_CYC));

  // R5: a pulse begins only with a watchdog-mode timeout that raised the flag
  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> (alarm_flag && $past(mode_wd)));

  // R3 / R4: the count moves only by a single decrement or a seed reload
  assert_count_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != $past(cnt)) && !$past(wr_en) && !$past(kick)) |->
      ((cnt == $past(cnt) - CNT_W'(1)) || (cnt == $past(seed))));

  // R4: a halted watchdog stays at zero
  assert_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wd && (cnt == '0) && !wr_en && !kick) |=> (cnt == '0));

  // R9: the disabled counter holds its value
  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en) |=> $stable(cnt));

  // R10: the flag never rises while the seed is zero
  assert_zero_seed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> ($past(seed) != '0));
endmodule

bind wdalm_counter wdalm_counter_chk #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_wd(mode_wd), .wr_en(wr_en),
  .alarm_flag(alarm_flag), .irq_oe(irq_oe), .cnt(cnt_q), .seed(seed_q), .kick(kick)
);

// File: tb/wdalm_counter_test.sv
module wdalm_counter_test;
  localparam int TD = 3;
  localparam int ST = 5;
  localparam int PT = 4;
  localparam int PC = TD * PT;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] addr;
  logic wr_en, rd_en, cnt_en, mode_wd, int_en, int_sel, flag_clr, strobe;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic alarm_flag, irq_oe, irq_drv;

  always #2.5 clk = ~clk;

  wdalm_counter #(.TICK_DIV(TD), .SEC_TICKS(ST), .PULSE_TICKS(PT)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .mode_wd(mode_wd),
    .int_en(int_en), .int_sel(int_sel), .flag_clr(flag_clr), .strobe(strobe),
    .alarm_flag(alarm_flag), .irq_oe(irq_oe), .irq_drv(irq_drv)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_rs, m_div, m_sec, m_pc, bi;
  logic [23:0] m_cnt, m_seed, m_snap;
  logic [7:0]  m_rd;
  bit m_flag, m_act, s1, s2, s3;
  bit rise, lvl, run, inr, tick, secw, kick, stp, tmo, pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_div = 0; m_sec = 0; m_pc = 0;
      m_cnt = 0; m_seed = 0; m_snap = 0; m_rd = 0;
      m_flag = 0; m_act = 0; s1 = 0; s2 = 0; s3 = 0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      rise = s2 && !s3;
      lvl  = s2;
      run  = cnt_en && (m_seed != 0);
      inr  = (addr >= 4) && (addr <= 6);
      bi   = int'(addr) - 4;
      tick = (m_div == TD - 1);
      secw = tick && (m_sec == ST - 1);
      kick = run && (rise || (rd_en && inr && mode_wd && !lvl));
      stp  = run && (mode_wd ? tick : secw);
      tmo  = 0;
      pend = m_act && (m_pc == PC - 1);
      if (rd_en) begin
        if (!inr) m_rd = 8'h00;
        else if (bi == 0) begin m_rd = m_cnt[7:0]; m_snap = m_cnt; end
        else m_rd = m_snap[8*bi +: 8];
      end
      if (wr_en && inr) begin
        m_seed[8*bi +: 8] = wdata;
        m_cnt = m_seed; m_div = 0; m_sec = 0;
      end else if (kick) begin
        m_cnt = m_seed; m_div = 0; m_sec = 0;
      end else begin
        if (stp) begin
          if (mode_wd) begin
            if (m_cnt == 1) begin m_cnt = 0; tmo = 1; end
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
          end else begin
            if (m_cnt <= 1) begin m_cnt = m_seed; tmo = 1; end
            else m_cnt = m_cnt - 1;
          end
        end
        if (tick) begin
          m_div = 0;
          m_sec = (m_sec == ST - 1) ? 0 : m_sec + 1;
        end else m_div++;
      end
      if (m_act) begin
        if (pend) begin m_act = 0; m_pc = 0; end
        else m_pc++;
      end else if (tmo && mode_wd && int_en && int_sel) begin
        m_act = 1; m_pc = 0;
      end
      if (tmo) m_flag = 1;
      else if (flag_clr || pend) m_flag = 0;
      s3 = s2; s2 = s1; s1 = strobe;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(cur_req, "rdata", 32'(rdata), 32'(m_rd));
      chk(cur_req, "alarm_flag", 32'(alarm_flag), 32'(m_flag));
      chk(cur_req, "irq_oe", 32'(irq_oe), 32'(m_act));
      chk("R5", "irq_drv", 32'(irq_drv), 32'd0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic load(input logic [23:0] s);
    wr(3'd6, s[23:16]);
    wr(3'd5, s[15:8]);
    wr(3'd4, s[7:0]);
  endtask

  logic [7:0] v;

  initial begin
    rst_n = 1'b0; addr = 0; wr_en = 0; rd_en = 0; wdata = 0;
    cnt_en = 0; mode_wd = 0; int_en = 0; int_sel = 0; flag_clr = 0; strobe = 0;
    idle(3);
    cur_req = "R1";
    chk("R1", "rdata in reset", 32'(rdata), 0);
    chk("R1", "flag in reset", 32'(alarm_flag), 0);
    chk("R1", "irq_oe in reset", 32'(irq_oe), 0);
    rst_n = 1'b1;
    idle(4);

    // storage with counting disabled
    cur_req = "R2";
    wr(3'd4, 8'h11); wr(3'd5, 8'h22); wr(3'd6, 8'h33);
    rd(3'd4, v); chk("R2", "byte4", 32'(v), 32'h11);
    rd(3'd5, v); chk("R2", "byte5", 32'(v), 32'h22);
    rd(3'd6, v); chk("R2", "byte6", 32'(v), 32'h33);
    cur_req = "R9";
    idle(100);
    rd(3'd4, v); chk("R9", "byte4 held", 32'(v), 32'h11);
    chk("R9", "flag off", 32'(alarm_flag), 0);
    cur_req = "R6";
    rd(3'd7, v); chk("R6", "unmapped", 32'(v), 0);

    // repeating alarm
    cur_req = "R3";
    cnt_en = 1;
    load(24'h000003);
    idle(60);
    chk("R3", "alarm flag", 32'(alarm_flag), 1);
    cur_req = "R11";
    flag_clr = 1; idle(1); flag_clr = 0;
    chk("R11", "flag cleared", 32'(alarm_flag), 0);
    cur_req = "R3";
    idle(50);
    chk("R3", "flag again", 32'(alarm_flag), 1);
    flag_clr = 1; idle(1); flag_clr = 0;

    // snapshot reads in alarm mode
    cur_req = "R6";
    load(24'h000100);
    rd(3'd4, v); chk("R6", "snap low", 32'(v), 32'h00);
    rd(3'd5, v); chk("R6", "snap mid", 32'(v), 32'h01);
    rd(3'd6, v); chk("R6", "snap top", 32'(v), 32'h00);
    idle(40);
    rd(3'd4, v); rd(3'd5, v);
    idle(5);

    // watchdog with interrupt pulse
    cur_req = "R5";
    mode_wd = 1; int_en = 1; int_sel = 1;
    load(24'h000004);
    idle(14);
    chk("R5", "pulse on", 32'(irq_oe), 1);
    flag_clr = 1; int_en = 0; idle(1); flag_clr = 0;
    idle(3);
    chk("R5", "pulse not truncated", 32'(irq_oe), 1);
    idle(15);
    chk("R5", "pulse over", 32'(irq_oe), 0);
    chk("R5", "flag auto clear", 32'(alarm_flag), 0);

    // halt after timeout, strobe kick restarts
    cur_req = "R4";
    strobe = 1;
    idle(25);
    chk("R4", "halt flag", 32'(alarm_flag), 1);
    chk("R4", "no pulse without enable", 32'(irq_oe), 0);
    rd(3'd4, v); chk("R4", "halted count", 32'(v), 0);

    // reads with strobe high do not kick
    cur_req = "R7";
    flag_clr = 1; idle(1); flag_clr = 0;
    rd(3'd4, v); idle(10);
    chk("R7", "no kick while strobe high", 32'(alarm_flag), 0);
    strobe = 0; idle(4);
    load(24'h000006);
    for (int i = 0; i < 8; i++) begin
      idle(9);
      rd(3'd5, v);
    end
    chk("R7", "read kicks keep alive", 32'(alarm_flag), 0);

    // strobe edges keep the watchdog alive
    cur_req = "R8";
    for (int i = 0; i < 8; i++) begin
      strobe = 1; idle(6);
      strobe = 0; idle(6);
    end
    chk("R8", "strobe kicks keep alive", 32'(alarm_flag), 0);
    idle(30);
    chk("R8", "timeout after kicks stop", 32'(alarm_flag), 1);

    // zero seed disables
    cur_req = "R10";
    load(24'h000000);
    flag_clr = 1; idle(1); flag_clr = 0;
    idle(60);
    mode_wd = 0;
    idle(100);
    chk("R10", "zero seed no flag", 32'(alarm_flag), 0);
    rd(3'd4, v); chk("R10", "zero count", 32'(v), 0);

    idle(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule